// File: doc/BRIEF.md
# Serial Divider Programming Bank

This block is the programming front end of a two-channel frequency synthesizer, with an IF channel and an RF channel. A controller sends 22-bit frames over three lines: serial data, a serial clock and a load strobe. The bits enter a shift register, most significant bit first. When the load strobe rises, the two bits received last pick one of four holding registers: the IF reference divider, the RF reference divider, the IF main divider or the RF main divider. That register takes the payload bits that sit just above the control bits. The other three registers keep their values.

A reference divide word must be at least 3. A load that would put a smaller value into a reference register is refused. That register keeps its old ratio, and a sticky error flag is raised that only reset clears. All three serial lines are sampled on the system clock `clk`. Each is treated as synchronous to that clock, and the block acts on their rising edges.

Top module: `progbank_top`

## Requirements
- R1: On each rising edge of `ser_clk` (seen at a `clk` edge), the value of `ser_data` is shifted in at frame bit 0 and all earlier bits move up one place. The register keeps the 22 most recent bits, so bits sent earlier than those 22 are lost.
- R2: The control code is {frame bit 1, frame bit 0}: the second-to-last bit shifted in, then the last bit. Code 00 selects the IF reference register, 01 the RF reference register, 10 the IF main register and 11 the RF main register.
- R3: Only a rising edge of `load` writes a register, and it writes only the register that the code selects. The other three keep their values.
- R4: A reference register takes frame bits 16..2, which is 15 bits. The value 3 and the value 32767 are both accepted.
- R5: The IF main register takes frame bits 16..2 (15 bits). The RF main register takes frame bits 19..2 (18 bits). Payload bits above a register's width are ignored.
- R6: A load into a reference register whose value is below 3 is refused. The register keeps its previous value.
- R7: `ref_err` goes high on the first refused load. It stays high through later loads, whether they are accepted or not, until reset.
- R8: While synchronous reset `rst` is high, both reference registers go to 3, both main registers go to 0 and `ref_err` goes to 0.
- R9: Shifting bits without a rising edge of `load` changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk | input | 1 | Serial bit clock; a rising edge shifts one bit in |
| ser_data | input | 1 | Serial data, most significant bit first |
| load | input | 1 | Load strobe; a rising edge writes the selected register |
| if_ref_div | output | 15 | IF reference divide ratio |
| rf_ref_div | output | 15 | RF reference divide ratio |
| if_main_div | output | 15 | IF main divide value |
| rf_main_div | output | 18 | RF main divide value |
| ref_err | output | 1 | Sticky flag for a refused reference word |

## Verification
The bench loads reference words of 2, 0, 3 and 32767. A design with an off-by-one range test would either accept 2 or refuse 3, and the bench would see the wrong value in the register. It also sends frames with every payload bit set. A design that took the wrong field would put the ignored high bits into the narrow registers, or cut the 18-bit RF main value short. Other checks cover extra leading bits that must fall off the register, frames shifted with no load, and accepted loads that follow an error. A design that got these wrong would show a corrupted frame, an update without a strobe, or an error flag that clears by itself.

// File: rtl/progbank_pkg.sv
package progbank_pkg;
  localparam int FRAME_W  = 22;
  localparam int CTRL_W   = 2;
  localparam int PAY_W    = FRAME_W - CTRL_W;
  localparam int REF_W    = 15;
  localparam int IFN_W    = 15;
  localparam int RFN_W    = 18;
  localparam int SLOT_W   = 18;
  localparam int N_SLOTS  = 4;
  localparam int REF_MIN  = 3;

  typedef logic [FRAME_W-1:0] frame_t;
  typedef logic [SLOT_W-1:0]  slot_t;

  // destination codes: {C1, C2}
  typedef enum logic [1:0] {
    DST_IF_REF  = 2'b00,
    DST_RF_REF  = 2'b01,
    DST_IF_MAIN = 2'b10,
    DST_RF_MAIN = 2'b11
  } dest_e;

  function automatic logic [1:0] frame_code(frame_t f);
    return f[CTRL_W-1:0];
  endfunction

  function automatic int slot_width(int idx);
    case (idx)
      0, 1:    return REF_W;
      2:       return IFN_W;
      default: return RFN_W;
    endcase
  endfunction

  function automatic bit slot_is_ref(int idx);
    return (idx < 2);
  endfunction

  function automatic slot_t slot_reset(int idx);
    return slot_is_ref(idx) ? slot_t'(REF_MIN) : '0;
  endfunction

  // payload bits directly above the control bits, trimmed to width w
  function automatic slot_t slot_field(frame_t f, int w);
    logic [PAY_W-1:0] pay;
    slot_t r;
    pay = f[FRAME_W-1:CTRL_W];
    for (int b = 0; b < SLOT_W; b++) begin
      r[b] = (b < w) ? pay[b] : 1'b0;
    end
    return r;
  endfunction

  function automatic bit ref_legal(slot_t v);
    return (v >= slot_t'(REF_MIN));
  endfunction
endpackage

// File: rtl/pe_detect.sv
module pe_detect #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= '1;
    else     lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/prog_shift.sv
module prog_shift
  import progbank_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   shift_evt,
  input  logic   din,
  output frame_t frame
);
  always_ff @(posedge clk) begin
    if (rst)            frame <= '0;
    else if (shift_evt) frame <= {frame[FRAME_W-2:0], din};
  end

  // R1
  shift_in_chk: assert property (@(posedge clk) disable iff (rst)
    shift_evt |=> (frame[0] == $past(din)) &&
                  (frame[FRAME_W-1:1] == $past(frame[FRAME_W-2:0])));
  // R1
  shift_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_evt |=> $stable(frame));
endmodule

// File: rtl/prog_latch_bank.sv
module prog_latch_bank
  import progbank_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         load_evt,
  input  frame_t                       frame,
  output logic [N_SLOTS-1:0][SLOT_W-1:0] slot_q,
  output logic                         reject_evt,
  output logic                         err
);
  logic [1:0]         code;
  logic [N_SLOTS-1:0] sel;
  logic [N_SLOTS-1:0] accept;
  logic [N_SLOTS-1:0] refuse;

  assign code = frame_code(frame);

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
    localparam int    SW  = slot_width(i);
    localparam bit    ISR = slot_is_ref(i);
    localparam slot_t RV  = slot_reset(i);
    slot_t fld;
    logic  legal;

    assign fld       = slot_field(frame, SW);
    assign legal     = ISR ? ref_legal(fld) : 1'b1;
    assign sel[i]    = load_evt && (code == 2'(i));
    assign accept[i] = sel[i] && legal;
    assign refuse[i] = sel[i] && !legal;

    always_ff @(posedge clk) begin
      if (rst)            slot_q[i] <= RV;
      else if (accept[i]) slot_q[i] <= fld;
    end
  end

  assign reject_evt = |refuse;

  always_ff @(posedge clk) begin
    if (rst)             err <= 1'b0;
    else if (reject_evt) err <= 1'b1;
  end

  // R2
  one_dest_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel));
  // R9
  no_strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load_evt |=> $stable(slot_q));
  // R6
  refuse_keep_chk: assert property (@(posedge clk) disable iff (rst)
    reject_evt |=> $stable(slot_q));
  // R6
  ref_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_q[0] >= slot_t'(REF_MIN)) && (slot_q[1] >= slot_t'(REF_MIN)));
  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
  // R7
  err_set_chk: assert property (@(posedge clk) disable iff (rst)
    reject_evt |=> err);
endmodule

// File: rtl/progbank_top.sv
module progbank_top
  import progbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              load,
  output logic [REF_W-1:0]  if_ref_div,
  output logic [REF_W-1:0]  rf_ref_div,
  output logic [IFN_W-1:0]  if_main_div,
  output logic [RFN_W-1:0]  rf_main_div,
  output logic              ref_err
);
  logic [1:0] rise;
  logic       shift_evt;
  logic       load_evt;
  logic       reject_evt;
  frame_t     frame;
  logic [N_SLOTS-1:0][SLOT_W-1:0] slot_q;

  pe_detect #(.W(2)) u_edges (
    .clk  (clk),
    .rst  (rst),
    .lvl  ({load, ser_clk}),
    .rise (rise)
  );

  assign shift_evt = rise[0];
  assign load_evt  = rise[1];

  prog_shift u_shift (
    .clk       (clk),
    .rst       (rst),
    .shift_evt (shift_evt),
    .din       (ser_data),
    .frame     (frame)
  );

  prog_latch_bank u_bank (
    .clk        (clk),
    .rst        (rst),
    .load_evt   (load_evt),
    .frame      (frame),
    .slot_q     (slot_q),
    .reject_evt (reject_evt),
    .err        (ref_err)
  );

  assign if_ref_div  = slot_q[DST_IF_REF][REF_W-1:0];
  assign rf_ref_div  = slot_q[DST_RF_REF][REF_W-1:0];
  assign if_main_div = slot_q[DST_IF_MAIN][IFN_W-1:0];
  assign rf_main_div = slot_q[DST_RF_MAIN][RFN_W-1:0];

  // R8
  reset_vals_chk: assert property (@(posedge clk)
    rst |=> (if_ref_div == REF_W'(REF_MIN)) && (rf_ref_div == REF_W'(REF_MIN)) &&
            (if_main_div == '0) && (rf_main_div == '0) && !ref_err);
endmodule

// File: tb/sim_progbank_top.sv
module sim_progbank_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_data = 1'b0, load = 1'b0;
  logic [14:0] if_ref_div, rf_ref_div, if_main_div;
  logic [17:0] rf_main_div;
  logic        ref_err;

  int errors = 0;
  int checks = 0;

  typedef struct {
    logic [14:0] ifr, rfr, ifm;
    logic [17:0] rfm;
    logic        err;
    string       tag;
  } snap_t;

  snap_t sb[$];
  event  chk_ev;
  logic [14:0] m_ifr, m_rfr, m_ifm;
  logic [17:0] m_rfm;
  logic        m_err;

  always #10 clk = ~clk;

  progbank_top u0 (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data), .load(load),
    .if_ref_div(if_ref_div), .rf_ref_div(rf_ref_div), .if_main_div(if_main_div),
    .rf_main_div(rf_main_div), .ref_err(ref_err)
  );

  task automatic push(input string tag);
    snap_t s;
    s.ifr = m_ifr; s.rfr = m_rfr; s.ifm = m_ifm; s.rfm = m_rfm; s.err = m_err; s.tag = tag;
    sb.push_back(s);
    -> chk_ev;
    @(negedge clk);
  endtask

  task automatic model_reset();
    m_ifr = 15'd3; m_rfr = 15'd3; m_ifm = '0; m_rfm = '0; m_err = 1'b0;
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    model_reset();
    push(tag);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); ser_data = b; ser_clk = 1'b1;
    @(negedge clk); ser_clk = 1'b0;
  endtask

  task automatic send_frame(input logic [19:0] pay, input logic [1:0] code);
    logic [21:0] f;
    f = {pay, code};
    for (int i = 21; i >= 0; i--) send_bit(f[i]);
  endtask

  // strobe and apply the requirement rules to the model
  task automatic strobe(input logic [19:0] pay, input logic [1:0] code, input string tag);
    @(negedge clk); load = 1'b1;
    @(negedge clk); load = 1'b0;
    case (code)
      2'b00: if (pay[14:0] >= 15'd3) m_ifr = pay[14:0]; else m_err = 1'b1;
      2'b01: if (pay[14:0] >= 15'd3) m_rfr = pay[14:0]; else m_err = 1'b1;
      2'b10: m_ifm = pay[14:0];
      default: m_rfm = pay[17:0];
    endcase
    push(tag);
  endtask

  task automatic load_frame(input logic [19:0] pay, input logic [1:0] code, input string tag);
    send_frame(pay, code);
    strobe(pay, code, tag);
  endtask

  task automatic cmp(input string tag, input string what, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // monitor: pops expectations and compares with outputs
  initial begin
    forever begin
      @(chk_ev);
      #1;
      while (sb.size() > 0) begin
        snap_t s;
        s = sb.pop_front();
        cmp(s.tag, "if_ref", 18'(if_ref_div), 18'(s.ifr));
        cmp(s.tag, "rf_ref", 18'(rf_ref_div), 18'(s.rfr));
        cmp(s.tag, "if_main", 18'(if_main_div), 18'(s.ifm));
        cmp(s.tag, "rf_main", rf_main_div, s.rfm);
        cmp(s.tag, "err", 18'(ref_err), 18'(s.err));
      end
    end
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model_reset();
    do_reset("R8 reset values");
    load_frame(20'h0_1234, 2'b00, "R2 R4 IF ref load");
    load_frame(20'h0_0ABC, 2'b01, "R2 R3 RF ref load, IF ref held");
    load_frame(20'h0_5555, 2'b10, "R2 R5 IF main load");
    load_frame(20'h2_AAAA, 2'b11, "R2 R5 RF main 18-bit load");
    load_frame(20'hF_FFFF, 2'b10, "R5 IF main upper bits ignored");
    load_frame(20'hF_FFFF, 2'b11, "R5 RF main upper bits ignored");
    load_frame(20'hF_8003, 2'b00, "R4 ref boundary 3 with junk upper bits");
    load_frame(20'h0_7FFF, 2'b01, "R4 ref boundary 32767");
    send_frame(20'h0_0111, 2'b10);
    push("R9 shift without load strobe");
    strobe(20'h0_0111, 2'b10, "R3 load after idle shift");
    load_frame(20'h0_0002, 2'b00, "R6 ref value 2 refused");
    load_frame(20'h0_0000, 2'b01, "R6 R7 ref value 0 refused");
    load_frame(20'h0_0009, 2'b00, "R7 flag stays after good load");
    // extra leading bits must fall off the 22-bit register
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    send_frame(20'h0_0777, 2'b01);
    strobe(20'h0_0777, 2'b01, "R1 only last 22 bits kept");
    // a held strobe writes only once: shift new frame while load high
    send_frame(20'h0_0042, 2'b00);
    @(negedge clk); load = 1'b1;
    @(negedge clk);
    send_frame(20'h0_0055, 2'b00);
    @(negedge clk); load = 1'b0;
    m_ifr = 15'h0042;
    push("R3 held strobe loads once");
    do_reset("R8 R7 reset clears flag");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule